// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block carries one disk sector between the host's byte-wide data port and a backing sector store, by way of an on-chip byte buffer. A command sequencer pulses `start_rd` or `start_wr`. On a read, the engine first fills the whole buffer from the store, one byte at a time. It then offers the bytes to the host in order. On a write, the engine collects bytes from the host and, once the sector is complete, commits the buffer to the store. The host polls two flags to pace each transfer. BUSY means a transfer is in progress. DRQ means the data port is ready for the next byte.

The store address of the first byte of a sector is computed from three inputs: the side, taken from one bit of a control flags byte, the track number, and the one-based sector number. A separate auxiliary status byte reports DRQ and BUSY. Reading that byte acknowledges DRQ, which lets a host that polls it tell that each DRQ is a fresh request.

Top module: `sector_xfer_engine`

## Requirements
- R1: After reset, BUSY and DRQ are low, `xfer_status` and `aux_rdata` are 0x00, `st_req` is low and `host_rdata` is 0xFF.
- R2: The base store address is (sector-1)*512 + track*4608 + side*368640, where side is bit 3 of `flags_reg` and the other bits of `flags_reg` have no effect. Sectors run 1..9 and tracks 0..79. Byte i of a sector sits at base+i.
- R3: An accepted read start sets BUSY (bit 0 of `xfer_status`) with DRQ (bit 1) low. The engine then issues 512 store reads (`st_we` low) at consecutive addresses. It keeps one request outstanding at a time and advances only on `st_ack`. DRQ stays low whenever `st_req` is high.
- R4: After the fill, DRQ rises. Each host data read returns the next buffered byte in store order, and DRQ is set again after every byte except the last.
- R5: The 512th host data read clears BUSY and DRQ and returns the engine to idle.
- R6: When no read transfer is delivering bytes, `host_rdata` is 0xFF, and a host data read has no effect.
- R7: An accepted write start sets BUSY and DRQ at once, so `xfer_status` reads 0x03. Each host data write then stores the next byte, starting at byte 0.
- R8: After the 512th host write, DRQ clears and the engine issues 512 store writes of byte i at base+i, with DRQ low throughout. BUSY clears when the last write is acknowledged.
- R9: `aux_rdata` carries DRQ in bit 7 and BUSY in bit 6, with the other bits 0. Reading it (`aux_rd`) clears DRQ. If a data transfer sets DRQ in the same cycle, the set wins.
- R10: A start pulse that arrives while BUSY is high is ignored. A host data write outside the write-collection phase is ignored.
- R11: If `start_rd` and `start_wr` arrive together while the engine is idle, the read is performed.
- R12: A store request holds its address and direction stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_rd | input | 1 | Start-read pulse from the command sequencer |
| start_wr | input | 1 | Start-write pulse from the command sequencer |
| flags_reg | input | 8 | Control flags byte; bit 3 selects the side |
| track_num | input | 7 | Track number, 0..79 |
| sector_num | input | 4 | Sector number, 1..9 |
| host_rd | input | 1 | Host data-port read strobe |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Next read byte, or 0xFF outside a read delivery |
| aux_rd | input | 1 | Auxiliary status read strobe (clears DRQ) |
| aux_rdata | output | 8 | Auxiliary status: DRQ bit 7, BUSY bit 6 |
| xfer_status | output | 8 | Transfer status: BUSY bit 0, DRQ bit 1 |
| st_req | output | 1 | Store byte request |
| st_we | output | 1 | Store request is a write |
| st_addr | output | 20 | Store byte address |
| st_wdata | output | 8 | Store write byte |
| st_rdata | input | 8 | Store read byte, valid with `st_ack` |
| st_ack | input | 1 | Store acknowledge, one per request |

## Verification
The cases hardest to reach from the ports are the ones where an action lands exactly on a transfer boundary or coincides with another event. Examples are an auxiliary read in the same cycle as a data read that sets DRQ again, start pulses during the fill and during write collection, and simultaneous read and write starts from idle. The stimulus paces itself from the reference model's phase, so it can place these events in chosen cycles. It also inserts isolated auxiliary reads between bytes, while the store acknowledges after a varying pseudo-random delay. The reference model runs on every clock, so any early or late flag change shows up at once.

// File: rtl/sxe_pkg.sv
package sxe_pkg;

   typedef enum logic [2:0] {
      XS_IDLE  = 3'd0,
      XS_FILL  = 3'd1,
      XS_HRD   = 3'd2,
      XS_HWR   = 3'd3,
      XS_FLUSH = 3'd4
   } xfer_state_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sxe_addr_map.sv
module sxe_addr_map #(
   parameter int SEC_BYTES    = 512,
   parameter int SECS_PER_TRK = 9,
   parameter int TRACKS       = 80,
   parameter int TRK_W        = 7,
   parameter int SEC_W        = 4,
   parameter int ADDR_W       = 20
) (
   input  logic              side,
   input  logic [TRK_W-1:0]  track,
   input  logic [SEC_W-1:0]  sector,
   output logic [ADDR_W-1:0] base
);
   import sxe_pkg::*;

   localparam int TRK_BYTES  = SEC_BYTES * SECS_PER_TRK;
   localparam int SIDE_BYTES = TRK_BYTES * TRACKS;

   logic [SEC_W-1:0]  sec_idx;
   logic [ADDR_W-1:0] sec_off;
   logic [ADDR_W-1:0] trk_off;
   logic [ADDR_W-1:0] side_off;

   assign sec_idx = sector - SEC_W'(1);

   generate
      if (is_pow2(SEC_BYTES)) begin : g_shift
         assign sec_off = ADDR_W'(sec_idx) << $clog2(SEC_BYTES);
      end else begin : g_mul
         assign sec_off = ADDR_W'(sec_idx) * ADDR_W'(SEC_BYTES);
      end
   endgenerate

   assign trk_off  = ADDR_W'(track) * ADDR_W'(TRK_BYTES);
   assign side_off = side ? ADDR_W'(SIDE_BYTES) : '0;
   assign base     = sec_off + trk_off + side_off;

endmodule

// File: rtl/sxe_buffer.sv
module sxe_buffer #(
   parameter int DEPTH = 512,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/sxe_flags.sv
module sxe_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_set,
   input  logic busy_clr,
   input  logic drq_set,
   input  logic drq_clr,
   output logic busy,
   output logic drq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         drq  <= 1'b0;
      end else begin
         if (busy_set)      busy <= 1'b1;
         else if (busy_clr) busy <= 1'b0;
         if (drq_set)       drq  <= 1'b1;
         else if (drq_clr)  drq  <= 1'b0;
      end
   end
endmodule

// File: rtl/sector_xfer_engine.sv
module sector_xfer_engine #(
   parameter int SEC_BYTES    = 512,
   parameter int SECS_PER_TRK = 9,
   parameter int TRACKS       = 80,
   parameter int SIDE_BIT     = 3,
   localparam int TRK_W  = $clog2(TRACKS),
   localparam int SEC_W  = $clog2(SECS_PER_TRK + 1),
   localparam int ADDR_W = $clog2(SEC_BYTES * SECS_PER_TRK * TRACKS * 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rd,
   input  logic              start_wr,
   input  logic [7:0]        flags_reg,
   input  logic [TRK_W-1:0]  track_num,
   input  logic [SEC_W-1:0]  sector_num,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              aux_rd,
   output logic [7:0]        aux_rdata,
   output logic [7:0]        xfer_status,
   output logic              st_req,
   output logic              st_we,
   output logic [ADDR_W-1:0] st_addr,
   output logic [7:0]        st_wdata,
   input  logic [7:0]        st_rdata,
   input  logic              st_ack
);
   import sxe_pkg::*;

   localparam int CNT_W = $clog2(SEC_BYTES);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SEC_BYTES - 1);

   generate
      if (SEC_BYTES < 2) begin : g_bad_bytes
         $error("SEC_BYTES must be at least 2");
      end
      if (SECS_PER_TRK < 1) begin : g_bad_secs
         $error("SECS_PER_TRK must be at least 1");
      end
      if (TRACKS < 2) begin : g_bad_tracks
         $error("TRACKS must be at least 2");
      end
      if (SIDE_BIT < 0 || SIDE_BIT > 7) begin : g_bad_side
         $error("SIDE_BIT must index the flags byte");
      end
   endgenerate

   xfer_state_t       state_q, state_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] base_q, base_calc;
   logic              last, accept_rd, accept_wr;
   logic              fill_ack, flush_ack, hrd_ev, hwr_ev, adv;
   logic              busy, drq, busy_set, busy_clr, drq_set, drq_clr;
   logic              buf_we;
   logic [7:0]        buf_wdata, buf_rdata;
   logic              flags_unused;

   assign flags_unused = ^flags_reg;

   sxe_addr_map #(
      .SEC_BYTES   (SEC_BYTES),
      .SECS_PER_TRK(SECS_PER_TRK),
      .TRACKS      (TRACKS),
      .TRK_W       (TRK_W),
      .SEC_W       (SEC_W),
      .ADDR_W      (ADDR_W)
   ) u_map (
      .side  (flags_reg[SIDE_BIT]),
      .track (track_num),
      .sector(sector_num),
      .base  (base_calc)
   );

   assign last      = (cnt_q == LAST_IDX);
   assign accept_rd = (state_q == XS_IDLE) && start_rd;
   assign accept_wr = (state_q == XS_IDLE) && start_wr && !start_rd;
   assign fill_ack  = (state_q == XS_FILL) && st_ack;
   assign flush_ack = (state_q == XS_FLUSH) && st_ack;
   assign hrd_ev    = (state_q == XS_HRD) && host_rd;
   assign hwr_ev    = (state_q == XS_HWR) && host_wr;
   assign adv       = fill_ack || flush_ack || hrd_ev || hwr_ev;

   always_comb begin
      state_d = state_q;
      case (state_q)
         XS_IDLE:  if (accept_rd) state_d = XS_FILL;
                   else if (accept_wr) state_d = XS_HWR;
         XS_FILL:  if (fill_ack && last) state_d = XS_HRD;
         XS_HRD:   if (hrd_ev && last) state_d = XS_IDLE;
         XS_HWR:   if (hwr_ev && last) state_d = XS_FLUSH;
         XS_FLUSH: if (flush_ack && last) state_d = XS_IDLE;
         default:  state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cnt_q   <= '0;
         base_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept_rd || accept_wr) begin
            cnt_q  <= '0;
            base_q <= base_calc;
         end else if (adv) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
         end
      end
   end

   assign busy_set = accept_rd || accept_wr;
   assign busy_clr = (hrd_ev && last) || (flush_ack && last);
   assign drq_set  = accept_wr || (fill_ack && last) || (hrd_ev && !last) || (hwr_ev && !last);
   assign drq_clr  = aux_rd || (hrd_ev && last) || (hwr_ev && last);

   sxe_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_set(busy_set),
      .busy_clr(busy_clr),
      .drq_set (drq_set),
      .drq_clr (drq_clr),
      .busy    (busy),
      .drq     (drq)
   );

   assign buf_we    = fill_ack || hwr_ev;
   assign buf_wdata = fill_ack ? st_rdata : host_wdata;

   sxe_buffer #(
      .DEPTH(SEC_BYTES),
      .AW   (CNT_W)
   ) u_buf (
      .clk  (clk),
      .we   (buf_we),
      .waddr(cnt_q),
      .wdata(buf_wdata),
      .raddr(cnt_q),
      .rdata(buf_rdata)
   );

   assign st_req      = (state_q == XS_FILL) || (state_q == XS_FLUSH);
   assign st_we       = (state_q == XS_FLUSH);
   assign st_addr     = base_q + ADDR_W'(cnt_q);
   assign st_wdata    = buf_rdata;
   assign host_rdata  = (state_q == XS_HRD) ? buf_rdata : 8'hFF;
   assign aux_rdata   = {drq, busy, 6'b000000};
   assign xfer_status = {6'b000000, drq, busy};

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_req && !st_ack) |=> (st_req && $stable(st_addr) && $stable(st_we)));

   // also covers the store flush of R8
   assert_no_drq_on_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st_req |-> !drq);

   assert_drq_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drq |-> busy);

   assert_aux_clears_drq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_rd && !host_rd && !host_wr && !st_ack && !start_wr) |=> !aux_rdata[7]);

   assert_idle_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (host_rdata == 8'hFF));

   assert_fill_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_ack && last) |=> (drq && busy && !st_req));

   assert_read_end_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hrd_ev && last) |=> (!busy && !drq));

   assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (start_rd || start_wr)) |=> $stable(base_q));

   assert_read_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_rd && start_wr) |=> (busy && !drq && st_req && !st_we));

endmodule

// File: tb/sector_xfer_engine_test.sv
module sector_xfer_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_rd = 0, start_wr = 0;
   logic [7:0]  flags_reg = 0;
   logic [6:0]  track_num = 0;
   logic [3:0]  sector_num = 1;
   logic        host_rd = 0, host_wr = 0;
   logic [7:0]  host_wdata = 0;
   logic [7:0]  host_rdata;
   logic        aux_rd = 0;
   logic [7:0]  aux_rdata, xfer_status;
   logic        st_req, st_we;
   logic [19:0] st_addr;
   logic [7:0]  st_wdata;
   logic [7:0]  st_rdata = 0;
   logic        st_ack = 0;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   bit done = 0;

   byte unsigned smem [int];

   // reference model state
   int   m_state = 0;  // 0 idle, 1 fill, 2 host read, 3 host write, 4 flush
   int   m_cnt = 0;
   int   m_base = 0;
   bit   m_busy = 0, m_drq = 0;
   logic [7:0] m_buf [NB];
   bit   m_last, m_dset, m_dclr;

   int   dly = 0;
   logic [15:0] lfsr = 16'hACE1;

   sector_xfer_engine uut (
      .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
      .flags_reg(flags_reg), .track_num(track_num), .sector_num(sector_num),
      .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .aux_rd(aux_rd), .aux_rdata(aux_rdata),
      .xfer_status(xfer_status), .st_req(st_req), .st_we(st_we),
      .st_addr(st_addr), .st_wdata(st_wdata), .st_rdata(st_rdata), .st_ack(st_ack)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int addr_of(input bit side, input int trk, input int sec);
      return (sec - 1) * 512 + trk * 4608 + (side ? 368640 : 0);
   endfunction

   function automatic logic [7:0] srd(input int a);
      if (smem.exists(a)) return smem[a];
      return 8'((a ^ (a >> 7)) & 255);
   endfunction

   function automatic logic [7:0] wpat(input int i, input int k);
      return 8'((i * 7 + k) & 255);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // backing store: one acknowledge per request after a varying delay
   always @(negedge clk) begin
      if (!rst_n) begin
         st_ack = 0;
         dly = 0;
      end else if (st_ack) begin
         st_ack = 0;
      end else if (st_req) begin
         if (dly == 0) begin
            st_ack = 1;
            if (st_we) smem[int'(st_addr)] = st_wdata;
            else st_rdata = srd(int'(st_addr));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dly = int'(lfsr[1:0]) % 3;
         end else begin
            dly--;
         end
      end
   end

   // behavioural reference model, advanced on each clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_base = 0; m_busy = 0; m_drq = 0;
      end else begin
         m_last = (m_cnt == NB - 1);
         m_dset = 0;
         m_dclr = aux_rd;
         case (m_state)
            0: if (start_rd) begin
                  m_base = addr_of(flags_reg[3], track_num, sector_num);
                  m_cnt = 0; m_state = 1; m_busy = 1;
               end else if (start_wr) begin
                  m_base = addr_of(flags_reg[3], track_num, sector_num);
                  m_cnt = 0; m_state = 3; m_busy = 1; m_dset = 1;
               end
            1: if (st_ack) begin
                  m_buf[m_cnt] = st_rdata;
                  if (m_last) begin m_cnt = 0; m_state = 2; m_dset = 1; end
                  else m_cnt++;
               end
            2: if (host_rd) begin
                  if (m_last) begin m_cnt = 0; m_state = 0; m_busy = 0; m_dclr = 1; end
                  else begin m_cnt++; m_dset = 1; end
               end
            3: if (host_wr) begin
                  m_buf[m_cnt] = host_wdata;
                  if (m_last) begin m_cnt = 0; m_state = 4; m_dclr = 1; end
                  else begin m_cnt++; m_dset = 1; end
               end
            default: if (st_ack) begin
                  if (m_last) begin m_cnt = 0; m_state = 0; m_busy = 0; end
                  else m_cnt++;
               end
         endcase
         if (m_dset) m_drq = 1;
         else if (m_dclr) m_drq = 0;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R7 status byte", {24'd0, xfer_status}, {30'd0, m_drq, m_busy});
         chk("R9 aux byte", {24'd0, aux_rdata}, {24'd0, m_drq, m_busy, 6'd0});
         chk("R12 store request", {31'd0, st_req}, (m_state == 1 || m_state == 4) ? 1 : 0);
         if (m_state == 1 || m_state == 4) begin
            chk("R2 store address", {12'd0, st_addr}, m_base + m_cnt);
            chk("R8 store direction", {31'd0, st_we}, (m_state == 4) ? 1 : 0);
         end
         if (m_state == 4) chk("R8 store data", {24'd0, st_wdata}, {24'd0, m_buf[m_cnt]});
         chk("R6 host read byte", {24'd0, host_rdata},
             (m_state == 2) ? {24'd0, m_buf[m_cnt]} : 32'hFF);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         report();
      end
   end

   task automatic select(input logic [7:0] f, input int trk, input int sec);
      flags_reg = f;
      track_num = 7'(trk);
      sector_num = 4'(sec);
   endtask

   task automatic aux_only();
      aux_rd = 1;
      @(negedge clk);
      aux_rd = 0;
      chk("R9 aux read clears DRQ", {24'd0, aux_rdata}, 32'h40);
   endtask

   task automatic rd_byte(input logic [7:0] exp, input bit with_aux, input bit is_last);
      while (m_state != 2) @(negedge clk);
      chk("R4 data byte", {24'd0, host_rdata}, {24'd0, exp});
      host_rd = 1;
      aux_rd = with_aux;
      @(negedge clk);
      host_rd = 0;
      aux_rd = 0;
      if (with_aux && !is_last) chk("R9 transfer set wins", {31'd0, aux_rdata[7]}, 1);
   endtask

   task automatic wr_byte(input logic [7:0] v);
      while (m_state != 3) @(negedge clk);
      host_wdata = v;
      host_wr = 1;
      @(negedge clk);
      host_wr = 0;
   endtask

   task automatic read_sector(input int base, input bit both_starts);
      start_rd = 1;
      start_wr = both_starts;
      @(negedge clk);
      start_rd = 0;
      start_wr = 0;
      if (both_starts) chk("R11 read chosen", {24'd0, xfer_status}, 32'h01);
      else chk("R3 busy without DRQ", {24'd0, xfer_status}, 32'h01);
      while (!st_req) @(negedge clk);
      chk("R2 first address", {12'd0, st_addr}, base);
      chk("R3 store read", {31'd0, st_we}, 0);
      repeat (40) @(negedge clk);
      start_wr = 1;                               // R10 ignored during fill
      @(negedge clk);
      start_wr = 0;
      for (int i = 0; i < NB; i++) begin
         if (i % 128 == 5) aux_only();
         rd_byte(srd(base + i), (i % 128 == 77) || (i == NB - 1), i == NB - 1);
      end
      chk("R5 idle after last byte", {24'd0, xfer_status}, 0);
      chk("R6 idle data 0xFF", {24'd0, host_rdata}, 32'hFF);
   endtask

   task automatic write_sector(input int base, input int k);
      start_wr = 1;
      @(negedge clk);
      start_wr = 0;
      chk("R7 busy and DRQ", {24'd0, xfer_status}, 32'h03);
      for (int i = 0; i < NB; i++) begin
         if (i == 200) begin
            start_rd = 1;                         // R10 ignored during collection
            @(negedge clk);
            start_rd = 0;
         end
         if (i % 128 == 9) aux_only();
         wr_byte(wpat(i, k));
      end
      chk("R8 DRQ low in flush", {24'd0, xfer_status}, 32'h01);
      while (m_state != 0) @(negedge clk);
      @(negedge clk);
      chk("R8 idle after commit", {24'd0, xfer_status}, 0);
      for (int i = 0; i < NB; i++) chk("R8 committed byte", {24'd0, srd(base + i)}, {24'd0, wpat(i, k)});
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 reset status", {24'd0, xfer_status}, 0);
      chk("R1 reset aux", {24'd0, aux_rdata}, 0);
      chk("R1 reset request", {31'd0, st_req}, 0);
      chk("R1 reset data", {24'd0, host_rdata}, 32'hFF);
      rst_n = 1;
      @(negedge clk);

      host_rd = 1;
      host_wr = 1;
      host_wdata = 8'h55;
      chk("R6 idle read 0xFF", {24'd0, host_rdata}, 32'hFF);
      @(negedge clk);
      host_rd = 0;
      host_wr = 0;
      chk("R10 idle write ignored", {24'd0, xfer_status}, 0);
      chk("R6 idle read no effect", {24'd0, host_rdata}, 32'hFF);

      select(8'hF7, 3, 2);                        // side bit clear, others set
      read_sector(addr_of(0, 3, 2), 0);

      select(8'h08, 79, 9);
      write_sector(addr_of(1, 79, 9), 3);

      read_sector(addr_of(1, 79, 9), 1);

      select(8'hF7, 0, 1);
      write_sector(0, 11);

      repeat (3) @(negedge clk);
      done = 1;
      report();
   end

endmodule